// File: doc/BRIEF.md
# Floating-Point Round and Pack Unit

This unit is the last stage of a double-precision arithmetic pipeline. It receives an unpacked result and returns the packed 64-bit IEEE word together with an inexact flag and an overflow flag. The unpacked result has three parts: a sign, a biased exponent that is one bit wider than the packed field, and a significand. In the significand the hidden bit sits at position 62, the 52 fraction bits follow below it, and 10 extra precision bits sit underneath. A 3-bit mode code chooses how those 10 low bits are folded into the kept fraction. The modes are nearest with ties to even, nearest with ties away, toward minus infinity, toward plus infinity, toward zero, and a non-IEEE round-to-odd mode.

Rounding adds a mode-dependent increment into the 10 low bits and then drops them. A carry out of the significand bumps the exponent. A result whose exponent reaches the all-ones code overflows. It becomes infinity or the largest finite magnitude, depending on the mode and the increment. Round-to-odd always saturates to the largest finite magnitude and never produces infinity. The unit has one register stage, and a valid bit travels alongside the data. Subnormal results and NaN handling are left to other stages.

Top module: `fp_round_pack`

## Requirements
- R1: While reset is held, and until the first accepted input, outValid, outWord, outInexact, outOverflow and outIllegal are all zero.
- R2: An input taken with inValid high appears on the outputs one clock later with outValid high. A cycle with inValid low drives outValid low and leaves outWord and the flags unchanged.
- R3: The significand bit 62 is the hidden bit, bits 61..10 are the fraction and bits 9..0 are discarded. The output is {sign, exponent[10:0], fraction} at bits 63, 62..52 and 51..0. When bits 9..0 are zero and the exponent is below 0x7FF, every legal mode returns the input unchanged with outInexact low.
- R4: Mode 0 (nearest, ties to even) and mode 4 (nearest, ties away) add 0x200 to the discarded bits. In mode 0 the result LSB is cleared when the discarded bits were exactly 0x200.
- R5: Mode 1 (toward minus infinity) adds 0x3FF for negative values and 0 for positive ones. Mode 2 (toward plus infinity) adds 0x3FF for positive values and 0 for negative ones. Mode 3 (toward zero) adds nothing.
- R6: In mode 5 (round to odd), an inexact value always yields an odd fraction LSB. If the kept LSB is already 1 the value is truncated; otherwise it is set to 1.
- R7: A carry out of the significand during rounding raises the exponent by one and leaves a zero fraction.
- R8: When the rounded exponent is 0x7FF or above, the result overflows. The output is infinity (exponent all ones, fraction zero) if the mode added a nonzero increment. It is the largest finite value (exponent 0x7FE, fraction all ones) if the increment was zero, and always in mode 5. The input sign is kept in every case.
- R9: outInexact is high when any discarded bit is set, and on every overflow. outOverflow is high only on overflow.
- R10: Mode codes 6 and 7 produce an all-zero word with outIllegal high and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input value present this cycle |
| inSign | input | 1 | Sign of the unpacked value |
| inExp | input | 12 | Biased exponent, one bit wider than the packed field |
| inSig | input | 64 | Normalized significand with 10 extra low bits |
| inMode | input | 3 | Rounding mode code (0..5 legal) |
| outValid | output | 1 | Registered result valid |
| outWord | output | 64 | Packed double-precision result |
| outInexact | output | 1 | Result differs from the exact value |
| outOverflow | output | 1 | Result exponent exceeded the finite range |
| outIllegal | output | 1 | Mode code was not legal |

## Verification
The bench builds the unit with its default widths: an 11-bit exponent field, a 52-bit fraction and 10 guard bits, which together give the packed 64-bit double format. The input exponent is one bit wider than the packed field. This lets the bench present values that already lie past the finite range, so the saturating branch of the overflow logic is reached with a zero increment. The same widths also let an all-ones fraction at exponent 0x7FE carry into overflow, which exercises the choice between infinity and the largest finite value in each mode.

// File: rtl/fprnd_pkg.sv
package fprnd_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_DOWN      = 3'd1,
    RM_UP        = 3'd2,
    RM_ZERO      = 3'd3,
    RM_NEAR_AWAY = 3'd4,
    RM_ODD       = 3'd5
  } rndMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic incHalf;      // add half an LSB into the guard bits
    logic incFull;      // add all ones into the guard bits
    logic tieEven;      // clear LSB on an exact tie
    logic ovfSaturate;  // overflow goes to largest finite, not infinity
    logic illegal;      // mode code outside the legal set
  } rndCtrl_t;

endpackage

// File: rtl/fprnd_ctrl.sv
module fprnd_ctrl
  import fprnd_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sign,
  input  logic       keptLsb,
  output rndCtrl_t   ctrl
);

  logic anyInc;

  always_comb begin
    ctrl = '0;
    case (mode)
      RM_NEAR_EVEN: begin
        ctrl.incHalf = 1'b1;
        ctrl.tieEven = 1'b1;
      end
      RM_DOWN:      ctrl.incFull = sign;
      RM_UP:        ctrl.incFull = !sign;
      RM_ZERO:      ctrl.incFull = 1'b0;
      RM_NEAR_AWAY: ctrl.incHalf = 1'b1;
      RM_ODD:       ctrl.incFull = !keptLsb;
      default:      ctrl.illegal = 1'b1;
    endcase
    anyInc = ctrl.incHalf | ctrl.incFull;
    ctrl.ovfSaturate = (mode == RM_ODD) || !anyInc;
  end

endmodule

// File: rtl/fprnd_datapath.sv
module fprnd_datapath
  import fprnd_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int GUARD_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inValid,
  input  logic                          inSign,
  input  logic [EXP_W:0]                inExp,
  input  logic [FRAC_W+GUARD_W+1:0]     inSig,
  input  rndCtrl_t                      ctrl,
  output logic                          keptLsb,
  output logic                          outValid,
  output logic [EXP_W+FRAC_W:0]         outWord,
  output logic                          outInexact,
  output logic                          outOverflow,
  output logic                          outIllegal
);

  localparam int SIG_W  = FRAC_W + GUARD_W + 2;
  localparam int KEEP_W = FRAC_W + 2;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [GUARD_W-1:0] HALF_G  = {1'b1, {(GUARD_W-1){1'b0}}};
  localparam logic [EXP_W+1:0]   EXP_TOP = {2'b00, {EXP_W{1'b1}}};
  localparam logic [EXP_W-1:0]   EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  logic [GUARD_W-1:0] guardBits;
  logic [SIG_W-1:0]   incVal;
  logic [SIG_W-1:0]   sumSig;
  logic [KEEP_W-1:0]  keptAdj;
  logic               tieHit;
  logic               carryOut;
  logic [FRAC_W-1:0]  fracRnd;
  logic [EXP_W+1:0]   expRnd;
  logic               ovfHit;
  logic [WORD_W-1:0]  nextWord;
  logic               nextInexact;
  logic               nextOverflow;

  assign guardBits = inSig[GUARD_W-1:0];
  assign keptLsb   = inSig[GUARD_W];

  always_comb begin
    incVal = '0;
    if (ctrl.incFull)      incVal[GUARD_W-1:0] = '1;
    else if (ctrl.incHalf) incVal[GUARD_W-1:0] = HALF_G;
  end

  assign sumSig = inSig + incVal;
  assign tieHit = (guardBits == HALF_G);

  always_comb begin
    keptAdj = sumSig[SIG_W-1:GUARD_W];
    if (ctrl.tieEven && tieHit) keptAdj[0] = 1'b0;
  end

  assign carryOut = keptAdj[KEEP_W-1];
  assign fracRnd  = carryOut ? keptAdj[FRAC_W:1] : keptAdj[FRAC_W-1:0];
  assign expRnd   = {1'b0, inExp} + {{(EXP_W+1){1'b0}}, carryOut};
  assign ovfHit   = (expRnd >= EXP_TOP);

  always_comb begin
    nextWord     = '0;
    nextInexact  = 1'b0;
    nextOverflow = 1'b0;
    if (!ctrl.illegal) begin
      if (ovfHit) begin
        if (ctrl.ovfSaturate) nextWord = {inSign, EXP_MAXFIN, {FRAC_W{1'b1}}};
        else                  nextWord = {inSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
        nextWord = {inSign, expRnd[EXP_W-1:0], fracRnd};
      end
      nextInexact  = (|guardBits) | ovfHit;
      nextOverflow = ovfHit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outWord     <= '0;
      outInexact  <= 1'b0;
      outOverflow <= 1'b0;
      outIllegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outWord     <= nextWord;
        outInexact  <= nextInexact;
        outOverflow <= nextOverflow;
        outIllegal  <= ctrl.illegal;
      end
    end
  end

endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
  import fprnd_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int GUARD_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic                      inSign,
  input  logic [EXP_W:0]            inExp,
  input  logic [FRAC_W+GUARD_W+1:0] inSig,
  input  logic [2:0]                inMode,
  output logic                      outValid,
  output logic [EXP_W+FRAC_W:0]     outWord,
  output logic                      outInexact,
  output logic                      outOverflow,
  output logic                      outIllegal
);

  rndCtrl_t ctrl;
  logic     keptLsb;

  fprnd_ctrl u_ctrl (
    .mode    (inMode),
    .sign    (inSign),
    .keptLsb (keptLsb),
    .ctrl    (ctrl)
  );

  fprnd_datapath #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .GUARD_W (GUARD_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .inValid     (inValid),
    .inSign      (inSign),
    .inExp       (inExp),
    .inSig       (inSig),
    .ctrl        (ctrl),
    .keptLsb     (keptLsb),
    .outValid    (outValid),
    .outWord     (outWord),
    .outInexact  (outInexact),
    .outOverflow (outOverflow),
    .outIllegal  (outIllegal)
  );

endmodule

// File: rtl/fprnd_checker.sv
module fprnd_checker #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int GUARD_W = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      inValid,
  input logic [EXP_W:0]            inExp,
  input logic [FRAC_W+GUARD_W+1:0] inSig,
  input logic [2:0]                inMode,
  input logic                      outValid,
  input logic [EXP_W+FRAC_W:0]     outWord,
  input logic                      outInexact,
  input logic                      outOverflow,
  input logic                      outIllegal
);

  localparam logic [EXP_W:0]   EXP_LIM = {1'b0, {EXP_W{1'b1}}};
  localparam logic [EXP_W-1:0] EXP_MAXFIN = {{(EXP_W-1){1'b1}}, 1'b0};

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_exact_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inSig[GUARD_W-1:0] == '0 && inMode <= 3'd5 && inExp < EXP_LIM)
      |=> !outInexact);

  assert_odd_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inMode == 3'd5 && inSig[GUARD_W-1:0] != '0) |=> outWord[0]);

  assert_odd_no_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inMode == 3'd5) |=> (outWord[EXP_W+FRAC_W-1:FRAC_W] != {EXP_W{1'b1}}));

  assert_ovf_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outOverflow) |-> outInexact);

  assert_ovf_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outOverflow) |->
      ((outWord[EXP_W+FRAC_W-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) ||
       (outWord[EXP_W+FRAC_W-1:0] == {EXP_MAXFIN, {FRAC_W{1'b1}}})));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outIllegal) |-> (outWord == '0 && !outInexact && !outOverflow));

endmodule

bind fp_round_pack fprnd_checker #(
  .EXP_W   (EXP_W),
  .FRAC_W  (FRAC_W),
  .GUARD_W (GUARD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inValid     (inValid),
  .inExp       (inExp),
  .inSig       (inSig),
  .inMode      (inMode),
  .outValid    (outValid),
  .outWord     (outWord),
  .outInexact  (outInexact),
  .outOverflow (outOverflow),
  .outIllegal  (outIllegal)
);

// File: tb/fp_round_pack_bench.sv
module fp_round_pack_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [11:0] inExp = '0;
  logic [63:0] inSig = '0;
  logic [2:0]  inMode = '0;
  logic        outValid;
  logic [63:0] outWord;
  logic        outInexact;
  logic        outOverflow;
  logic        outIllegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [51:0] ONES52 = {52{1'b1}};
  localparam logic [63:0] POS_INF = 64'h7FF0000000000000;
  localparam logic [63:0] NEG_INF = 64'hFFF0000000000000;
  localparam logic [63:0] POS_MAX = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] NEG_MAX = 64'hFFEFFFFFFFFFFFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_pack u_fp_round_pack (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
    .inExp(inExp), .inSig(inSig), .inMode(inMode), .outValid(outValid),
    .outWord(outWord), .outInexact(outInexact), .outOverflow(outOverflow),
    .outIllegal(outIllegal)
  );

  function automatic logic [63:0] pk(input logic s, input logic [10:0] e, input logic [51:0] f);
    return {s, e, f};
  endfunction

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one value and check all outputs one cycle later
  task automatic runOne(input string tag, input logic s, input logic [11:0] e,
                        input logic [51:0] f, input logic [9:0] g, input logic [2:0] m,
                        input logic [63:0] expWord, input logic expInx,
                        input logic expOvf, input logic expIll);
    @(negedge clk);
    inValid = 1'b1; inSign = s; inExp = e; inSig = {1'b0, 1'b1, f, g}; inMode = m;
    @(negedge clk);
    inValid = 1'b0;
    checkVal({tag, " valid"}, {63'd0, outValid}, 64'd1);
    checkVal({tag, " word"}, outWord, expWord);
    checkVal({tag, " flags"}, {61'd0, outInexact, outOverflow, outIllegal},
             {61'd0, expInx, expOvf, expIll});
  endtask

  task automatic testReset();
    checkVal("R1 reset", {59'd0, outValid, outInexact, outOverflow, outIllegal, 1'b0}, 64'd0);
    checkVal("R1 reset word", outWord, 64'd0);
  endtask

  task automatic testExact();
    for (int m = 0; m < 6; m++) begin
      runOne("R3 exact", m[0], 12'h400, 52'h123456789ABCD, 10'h000, 3'(m),
             pk(m[0], 11'h400, 52'h123456789ABCD), 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic testNearest();
    runOne("R4 tie even stays", 1'b0, 12'h400, 52'd2, 10'h200, 3'd0, pk(0, 11'h400, 52'd2), 1, 0, 0);
    runOne("R4 tie odd up",     1'b0, 12'h400, 52'd3, 10'h200, 3'd0, pk(0, 11'h400, 52'd4), 1, 0, 0);
    runOne("R4 above half",     1'b0, 12'h400, 52'd2, 10'h201, 3'd0, pk(0, 11'h400, 52'd3), 1, 0, 0);
    runOne("R4 below half",     1'b1, 12'h400, 52'd3, 10'h1FF, 3'd0, pk(1, 11'h400, 52'd3), 1, 0, 0);
    runOne("R4 tie away",       1'b0, 12'h400, 52'd2, 10'h200, 3'd4, pk(0, 11'h400, 52'd3), 1, 0, 0);
  endtask

  task automatic testDirected();
    runOne("R5 down neg", 1'b1, 12'h400, 52'd5, 10'h001, 3'd1, pk(1, 11'h400, 52'd6), 1, 0, 0);
    runOne("R5 down pos", 1'b0, 12'h400, 52'd5, 10'h001, 3'd1, pk(0, 11'h400, 52'd5), 1, 0, 0);
    runOne("R5 up pos",   1'b0, 12'h400, 52'd5, 10'h001, 3'd2, pk(0, 11'h400, 52'd6), 1, 0, 0);
    runOne("R5 up neg",   1'b1, 12'h400, 52'd5, 10'h3FF, 3'd2, pk(1, 11'h400, 52'd5), 1, 0, 0);
    runOne("R5 zero",     1'b0, 12'h400, 52'd5, 10'h3FF, 3'd3, pk(0, 11'h400, 52'd5), 1, 0, 0);
  endtask

  task automatic testOdd();
    runOne("R6 even to odd", 1'b0, 12'h400, 52'd4, 10'h001, 3'd5, pk(0, 11'h400, 52'd5), 1, 0, 0);
    runOne("R6 odd kept",    1'b1, 12'h400, 52'd5, 10'h3FF, 3'd5, pk(1, 11'h400, 52'd5), 1, 0, 0);
    runOne("R6 exact even",  1'b0, 12'h400, 52'd4, 10'h000, 3'd5, pk(0, 11'h400, 52'd4), 0, 0, 0);
  endtask

  task automatic testCarry();
    runOne("R7 carry up",   1'b0, 12'h400, ONES52, 10'h3FF, 3'd2, pk(0, 11'h401, 52'd0), 1, 0, 0);
    runOne("R7 carry near", 1'b1, 12'h3FF, ONES52, 10'h300, 3'd4, pk(1, 11'h400, 52'd0), 1, 0, 0);
  endtask

  task automatic testOverflow();
    runOne("R8 up to inf",          1'b0, 12'h7FE, ONES52, 10'h3FF, 3'd2, POS_INF, 1, 1, 0);
    runOne("R8 down to neg inf",    1'b1, 12'h7FE, ONES52, 10'h001, 3'd1, NEG_INF, 1, 1, 0);
    runOne("R8 even tie to inf",    1'b0, 12'h7FE, ONES52, 10'h200, 3'd0, POS_INF, 1, 1, 0);
    runOne("R8 zero saturates",     1'b0, 12'h800, 52'd5,  10'h000, 3'd3, POS_MAX, 1, 1, 0);
    runOne("R8 up neg saturates",   1'b1, 12'h7FF, 52'd0,  10'h000, 3'd2, NEG_MAX, 1, 1, 0);
    runOne("R8 down pos saturates", 1'b0, 12'h7FF, 52'd9,  10'h011, 3'd1, POS_MAX, 1, 1, 0);
    runOne("R8 odd saturates",      1'b0, 12'h7FF, 52'd0,  10'h001, 3'd5, POS_MAX, 1, 1, 0);
    runOne("R9 odd at max no ovf",  1'b1, 12'h7FE, ONES52, 10'h001, 3'd5, NEG_MAX, 1, 0, 0);
    runOne("R9 up neg at max",      1'b1, 12'h7FE, ONES52, 10'h3FF, 3'd2, NEG_MAX, 1, 0, 0);
  endtask

  task automatic testIllegal();
    runOne("R10 mode 6", 1'b1, 12'h400, 52'd7, 10'h155, 3'd6, 64'd0, 0, 0, 1);
    runOne("R10 mode 7", 1'b0, 12'h7FF, ONES52, 10'h3FF, 3'd7, 64'd0, 0, 0, 1);
  endtask

  task automatic testHold();
    runOne("R2 load", 1'b0, 12'h400, 52'd4, 10'h001, 3'd2, pk(0, 11'h400, 52'd5), 1, 0, 0);
    @(negedge clk);
    inSign = 1'b1; inExp = 12'h7FF; inSig = '1; inMode = 3'd0;
    @(negedge clk);
    checkVal("R2 idle valid", {63'd0, outValid}, 64'd0);
    checkVal("R2 idle hold word", outWord, pk(0, 11'h400, 52'd5));
    checkVal("R2 idle hold flags", {61'd0, outInexact, outOverflow, outIllegal}, {61'd0, 3'b100});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testExact();
    testNearest();
    testDirected();
    testOdd();
    testCarry();
    testOverflow();
    testIllegal();
    testHold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule